// File: doc/BRIEF.md
# Segmented Byte-Wide Bus Interface

This block sits between a processor core and an external 8-bit bus on which the low address byte and the data byte share one set of pins. The core presents a request with a 16-bit segment, a 16-bit offset, a byte or word size, a read or write direction and a memory or I/O select. The block forms a 20-bit physical address by shifting the segment left four places and adding the offset. It then runs one byte cycle for a byte access, or two for a word access. Each byte cycle drives the latch enable, the read and write strobes, the direction and data-enable controls and the upper address lines, and waits on a ready input.

A word goes out least significant byte first. The low byte uses the computed address and the high byte uses that address plus one, with the 20-bit address wrapping from 0xFFFFF to 0x00000. For reads, the bytes taken from the shared pins are assembled into a 16-bit result. A one-cycle done pulse marks the end of the access.

The controller has six states. IDLE goes to T1 when a request is present. T1 (address latch) goes to T2. T2 (strobe on, pins turned) goes to T3. T3 (wait) stays in T3 while ready is low and goes to T4 when ready is high. T4 (strobe off) goes back to T1 when the high byte of a word is still owed, and to DONE otherwise. DONE goes to IDLE. The shared pins are modelled as separate output, input and output-enable signals.

Top module: `seg_bus_if`

## Requirements
- R1: While reset is held and after reset is released, the block is idle: rd_n, wr_n and den_n are 1, ale is 0, ad_oe is 0 (shared pins released), done is 0 and busy is 0.
- R2: In the first byte cycle, the cycle with ale at 1 shows the physical address ((seg << 4) + off) mod 2^20, with bits 19..8 on addr_hi and bits 7..0 on ad_out, and ad_oe at 1.
- R3: Each byte cycle is one T1 cycle (ale 1), a T2 cycle and at least one T3 cycle with the strobe low, then one T4 cycle with the strobe high. T3 repeats while bus_ready is low, so the strobe stays low for max(2, W+1) cycles when ready is held low for the first W strobe cycles. During a read strobe, ad_oe is 0.
- R4: dt_r is 1 for the whole of a write and 0 for the whole of a read. den_n is 0 exactly while a strobe is low.
- R5: A write strobe drives ad_out with ad_oe at 1. A word write sends wdata[7:0] in the first byte cycle and wdata[15:8] in the second. A byte write sends wdata[7:0].
- R6: A word read returns rdata = {byte at address+1, byte at address}. A byte read returns {8'h00, byte}. Each byte is taken from ad_in at the clock edge that ends the last T3 cycle.
- R7: The second byte cycle of a word uses the first address plus one, modulo 2^20, so 0xFFFFF is followed by 0x00000.
- R8: io_sel equals the request's memory/I/O select (1 = I/O) in every cycle of the access.
- R9: A request is accepted only in IDLE. Requests presented while busy is 1 start no bus cycle. done is 1 for exactly one cycle, the cycle after T4 of the last byte cycle, and busy is 1 from the cycle after acceptance through that done cycle.
- R10: rd_n and wr_n are never both 0, and neither is 0 while ale is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read data, valid with done |
| addr_hi | output | 12 | Physical address bits 19..8 |
| ad_out | output | 8 | Shared pins, value driven |
| ad_oe | output | 1 | Shared pins output enable |
| ad_in | input | 8 | Shared pins, value received |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | Memory (0) or I/O (1) select |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| den_n | output | 1 | Data enable, active low |
| bus_ready | input | 1 | Target ready; low inserts wait cycles |

## Verification
The assertions check the per-cycle rules on every cycle: strobe exclusion against ale, a held strobe while ready is low, pin direction and data enable under each strobe, a steady memory/I/O select across an access, and a single-cycle done. Only the bench scenarios can show that the addresses are right, including the segment arithmetic and the wrap of the second byte past 0xFFFFF. The same holds for the byte order of word writes and reads, the exact number of strobe cycles for a given ready pattern, and that requests arriving while busy start no bus cycle.

// File: rtl/seg_bus_pkg.sv
`timescale 1ns/1ps
package seg_bus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4,
        ST_DONE
    } bus_state_e;
endpackage

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = SEG_W + SEG_SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    // segment base on a 16-byte boundary plus offset, truncated to PA_W bits
    always_comb begin
        phys = {seg, {SEG_SHIFT{1'b0}}} + PA_W'(off);
    end
endmodule

// File: rtl/seg_rd_collect.sv
`timescale 1ns/1ps
module seg_rd_collect #(
    parameter int BUS_W      = 8,
    parameter int XFER_BYTES = 2,
    localparam int IDX_W     = (XFER_BYTES > 1) ? $clog2(XFER_BYTES) : 1,
    localparam int DATA_W    = BUS_W * XFER_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [IDX_W-1:0]  lane,
    input  logic [BUS_W-1:0]  din,
    output logic [DATA_W-1:0] data
);
    for (genvar g = 0; g < XFER_BYTES; g++) begin : g_lane
        logic [BUS_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (clear) begin
                lane_q <= '0;
            end else if (capture && (lane == IDX_W'(g))) begin
                lane_q <= din;
            end
        end
        assign data[g*BUS_W +: BUS_W] = lane_q;
    end
endmodule

// File: rtl/seg_bus_if.sv
`timescale 1ns/1ps
module seg_bus_if
    import seg_bus_pkg::*;
#(
    parameter int SEG_W      = 16,
    parameter int OFF_W      = 16,
    parameter int SEG_SHIFT  = 4,
    parameter int BUS_W      = 8,
    parameter int XFER_BYTES = 2,
    localparam int PA_W      = SEG_W + SEG_SHIFT,
    localparam int HI_W      = PA_W - BUS_W,
    localparam int DATA_W    = BUS_W * XFER_BYTES,
    localparam int IDX_W     = (XFER_BYTES > 1) ? $clog2(XFER_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_word,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [HI_W-1:0]   addr_hi,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_sel,
    output logic              dt_r,
    output logic              den_n,
    input  logic              bus_ready
);
    bus_state_e state_q, state_d;

    logic [PA_W-1:0]   phys;
    logic [PA_W-1:0]   byte_addr_q;
    logic              word_q;
    logic              write_q;
    logic              io_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  idx_q;

    logic accept;
    logic more_bytes;
    logic strobe_on;
    logic rd_capture;

    seg_addr_gen #(
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) i_addr (
        .seg  (req_seg),
        .off  (req_off),
        .phys (phys)
    );

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign more_bytes = word_q && (idx_q != IDX_W'(XFER_BYTES - 1));
    assign strobe_on  = (state_q == ST_T2) || (state_q == ST_T3);
    assign rd_capture = (state_q == ST_T3) && bus_ready && !write_q;

    seg_rd_collect #(
        .BUS_W      (BUS_W),
        .XFER_BYTES (XFER_BYTES)
    ) i_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (rd_capture),
        .lane    (idx_q),
        .din     (ad_in),
        .data    (rdata)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   if (bus_ready) state_d = ST_T4;
            ST_T4:   state_d = more_bytes ? ST_T1 : ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latches and byte sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_addr_q <= '0;
            word_q      <= 1'b0;
            write_q     <= 1'b0;
            io_q        <= 1'b0;
            wdata_q     <= '0;
            idx_q       <= '0;
        end else if (accept) begin
            byte_addr_q <= phys;
            word_q      <= req_word;
            write_q     <= req_write;
            io_q        <= req_io;
            wdata_q     <= req_wdata;
            idx_q       <= '0;
        end else if ((state_q == ST_T4) && more_bytes) begin
            byte_addr_q <= byte_addr_q + PA_W'(1);
            idx_q       <= idx_q + IDX_W'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        ale     = (state_q == ST_T1);
        ad_oe   = (state_q == ST_T1) || (strobe_on && write_q);
        ad_out  = (state_q == ST_T1) ? byte_addr_q[BUS_W-1:0]
                                     : wdata_q[idx_q*BUS_W +: BUS_W];
        addr_hi = byte_addr_q[PA_W-1:BUS_W];
        rd_n    = !(strobe_on && !write_q);
        wr_n    = !(strobe_on && write_q);
        den_n   = !strobe_on;
        dt_r    = write_q;
        io_sel  = io_q;
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
    end
endmodule

// File: rtl/seg_bus_if_chk.sv
`timescale 1ns/1ps
module seg_bus_if_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ready,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dt_r,
    input logic ad_oe,
    input logic io_sel,
    input logic done,
    input logic busy
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R10
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));

    // R3
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (rd_n != wr_n)));

    // R3
    rd_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !bus_ready) |=> !rd_n);

    // R3
    wr_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !bus_ready) |=> !wr_n);

    // R3
    rd_pins_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe && !dt_r && !den_n));

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && dt_r && !den_n));

    // R8
    io_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(io_sel));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind seg_bus_if seg_bus_if_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ready (bus_ready),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dt_r      (dt_r),
    .ad_oe     (ad_oe),
    .io_sel    (io_sel),
    .done      (done),
    .busy      (busy)
);

// File: tb/test_seg_bus_if.sv
`timescale 1ns/1ps
module test_seg_bus_if;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic [11:0] addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic        ale, rd_n, wr_n, io_sel, dt_r, den_n;
    logic        bus_ready = 1'b0;

    seg_bus_if i_seg_bus_if (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_word(req_word), .req_write(req_write),
        .req_io(req_io), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
        .dt_r(dt_r), .den_n(den_n), .bus_ready(bus_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [19:0] addr;
        logic        wr;
        logic        io;
        logic [7:0]  data;
        logic        second;
    } cyc_t;

    cyc_t        exp_q[$];
    logic [15:0] res_q[$];
    logic        res_rd_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int done_seen = 0;
    int wait_cfg = 0;

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // monitor: bus target model and scoreboard
    cyc_t cur = '0;
    int   strobe_cnt = 0;
    bit   prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "bus cycle with no request", {12'h0, addr_hi, ad_out}, 0);
                end else begin
                    cur = exp_q.pop_front();
                    check({addr_hi, ad_out} == cur.addr, cur.second ? "R7" : "R2",
                          "latched address", {12'h0, addr_hi, ad_out}, {12'h0, cur.addr});
                    check(ad_oe == 1'b1, "R2", "pins driven in T1", ad_oe, 1);
                    check(dt_r == cur.wr, "R4", "direction", dt_r, cur.wr);
                    check(io_sel == cur.io, "R8", "mem/io select", io_sel, cur.io);
                    check(rd_n && wr_n, "R10", "strobes idle with ale", {rd_n, wr_n}, 2'b11);
                end
                ad_in = mb(cur.addr);
                strobe_cnt = 0;
                bus_ready = 1'b0;
            end else if (!rd_n || !wr_n) begin
                if (strobe_cnt == 0) begin
                    check(den_n == 1'b0, "R4", "data enable during strobe", den_n, 0);
                    check(io_sel == cur.io, "R8", "mem/io select in T2", io_sel, cur.io);
                    if (cur.wr)
                        check(!wr_n && rd_n && ad_oe && ad_out == cur.data, "R5",
                              "write byte", {wr_n, rd_n, ad_oe, ad_out}, {3'b011, cur.data});
                    else
                        check(!rd_n && wr_n && !ad_oe, "R3", "read strobe, pins free",
                              {rd_n, wr_n, ad_oe}, 3'b010);
                end
                bus_ready = (strobe_cnt >= wait_cfg);
                strobe_cnt++;
            end else if (strobe_cnt > 0) begin
                check(strobe_cnt == ((wait_cfg + 1 > 2) ? wait_cfg + 1 : 2), "R3",
                      "strobe length", strobe_cnt, (wait_cfg + 1 > 2) ? wait_cfg + 1 : 2);
                check(den_n == 1'b1, "R4", "data enable off in T4", den_n, 1);
                strobe_cnt = 0;
            end
            if (done) begin
                check(!prev_done, "R9", "done longer than one cycle", prev_done, 0);
                check(exp_q.size() == 0, "R9", "byte cycles left at done", exp_q.size(), 0);
                check(busy == 1'b1, "R9", "busy with done", busy, 1);
                if (res_q.size() > 0) begin
                    logic [15:0] er;
                    logic        isrd;
                    er = res_q.pop_front();
                    isrd = res_rd_q.pop_front();
                    if (isrd) check(rdata == er, "R6", "read data", rdata, er);
                end
                done_seen++;
            end
            prev_done = done;
        end
    end

    task automatic do_req(input logic [15:0] s, input logic [15:0] o, input logic w,
                          input logic wr, input logic io, input logic [15:0] wd,
                          input int wt);
        logic [19:0] p;
        int start;
        p = {s, 4'h0} + {4'h0, o};
        while (busy) @(negedge clk);
        wait_cfg = wt;
        exp_q.push_back('{p, wr, io, wd[7:0], 1'b0});
        if (w) exp_q.push_back('{p + 20'd1, wr, io, wd[15:8], 1'b1});
        res_q.push_back(w ? {mb(p + 20'd1), mb(p)} : {8'h00, mb(p)});
        res_rd_q.push_back(!wr);
        start = done_seen;
        req_seg = s; req_off = o; req_word = w; req_write = wr; req_io = io;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        // R9: requests while busy must start nothing
        req_seg = ~s; req_off = o + 16'h1234; req_write = ~wr; req_io = ~io;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (done_seen == start) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(rd_n && wr_n && den_n && !ale && !ad_oe && !done && !busy, "R1",
              "outputs in reset", {rd_n, wr_n, den_n, ale, ad_oe, done, busy}, 7'b1110000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rd_n && wr_n && den_n && !ale && !ad_oe && !done && !busy, "R1",
              "outputs after reset", {rd_n, wr_n, den_n, ale, ad_oe, done, busy}, 7'b1110000);

        do_req(16'hA000, 16'h5F00, 1'b0, 1'b0, 1'b0, 16'h0000, 0);  // byte read
        do_req(16'h1234, 16'h0011, 1'b1, 1'b1, 1'b0, 16'hBEEF, 0);  // word write
        do_req(16'h0040, 16'h0003, 1'b1, 1'b0, 1'b1, 16'h0000, 3);  // word read, io, waits
        do_req(16'h0100, 16'h00FF, 1'b1, 1'b1, 1'b0, 16'hC35A, 2);  // carry into addr_hi
        do_req(16'hF000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 16'h0000, 1);  // R7 wrap on read
        do_req(16'hFFFF, 16'h000F, 1'b1, 1'b1, 1'b1, 16'h7E81, 0);  // R7 wrap on write
        do_req(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 16'hAA55, 4);  // byte write, io

        repeat (5) @(negedge clk);
        check(!busy && rd_n && wr_n && !ad_oe, "R1", "idle after accesses",
              {busy, rd_n, wr_n, ad_oe}, 4'b0110);
        check(exp_q.size() == 0, "R9", "unused expected cycles", exp_q.size(), 0);
        report();
        $finish;
    end
endmodule